// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

The unit resolves where an instruction's operand lives and brings the operand back. A caller presents an addressing mode code, up to two register numbers, a signed 32-bit constant field, an access size and the current program counter, then pulses `start`. The unit reads its own small register file, issues one-word reads on a simple request/ready memory port as the mode requires, and ends with a one-cycle `done` pulse. At that point `operand` and `ea` are valid, and they hold until the next accepted `start`.

A controller steps through named states. IDLE waits for `start` and latches the request, moving to CALC. CALC forms the address. It moves to DONE for immediate and register modes, to IND_READ for memory-indirect mode, and to OP_READ for every other mode. IND_READ follows a chain of pointer words. A word whose bit 31 is clear ends the chain and moves to OP_READ. A flagged word repeats IND_READ. If the LEVEL_MAX-th word is still flagged, the state moves to DONE with `err` set. OP_READ waits for the operand word. It moves to WRITEBACK for the autoincrement and autodecrement modes and to DONE otherwise. WRITEBACK commits the register update once and moves to DONE. DONE lasts one cycle and returns to IDLE.

Mode codes: 0 immediate, 1 absolute, 2 register, 3 register indirect, 4 memory indirect, 5 indexed, 6 base+index, 7 base+index+offset, 8 autoincrement, 9 autodecrement, 10 PC-relative. Codes 11 to 15 behave as immediate. `byte_sz`=1 selects a byte access and 0 selects a word access.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `err` and `mem_req` are 0, and every register in the register file reads 0.
- R2: Immediate (code 0) returns `operand` = `cst` and `ea` = 0, and makes no memory read.
- R3: Absolute (code 1) gives `ea` = `cst` and reads the operand from there with exactly one memory read.
- R4: Register (code 2) returns `operand` = register `ra` with no memory read.
- R5: Register indirect (code 3) gives `ea` = register `ra`.
- R6: Indexed (code 5) gives `ea` = `cst` + register `ra` and leaves register `ra` unchanged.
- R7: Base+index (code 6) gives `ea` = reg `ra` + reg `rb`. Code 7 adds `cst` to that sum.
- R8: Memory indirect (code 4) first reads the word at `cst`. Each fetched word with bit 31 = 1 names the next pointer in bits 30:0. The first word with bit 31 = 0 gives `ea` = bits 30:0 zero-extended. Then one operand read follows.
- R9: If LEVEL_MAX (default 8) consecutive fetched words all have bit 31 set, `done` comes with `err` = 1, `operand` = 0 and `ea` = 0, and no operand read is made. A chain with LEVEL_MAX−1 flagged words still resolves without error.
- R10: Autoincrement (code 8) uses register `ra` as `ea`, then adds 4 (word) or 1 (byte) to the register. A byte operand is `mem_rdata[7:0]` zero-extended.
- R11: Autodecrement (code 9) subtracts 4 (word) or 1 (byte) from register `ra` first, and uses the new value as `ea`.
- R12: PC-relative (code 10) gives `ea` = `pc` + `cst`.
- R13: `done` lasts one cycle. `mem_req` with its `mem_addr` is held until `mem_ready`. A `start` that arrives while the unit is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a resolution (taken in IDLE only) |
| mode | input | 4 | Addressing mode code |
| ra | input | 3 | First register number |
| rb | input | 3 | Second register number |
| cst | input | 32 | Signed constant / address field |
| byte_sz | input | 1 | 1 = byte access, 0 = word access |
| pc | input | 32 | Program counter value |
| rf_we | input | 1 | Register file load enable |
| rf_waddr | input | 3 | Register file load index |
| rf_wdata | input | 32 | Register file load data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory read completes this cycle |
| operand | output | 32 | Fetched operand |
| ea | output | 32 | Final effective address |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Indirection limit exceeded |

## Verification
The bound assertions check properties that hold on every cycle. They check that `done` is a single-cycle pulse, that a pending request keeps its address until ready, that `err` only appears together with `done`, and that no resolution makes more reads than the indirection limit allows. The address arithmetic of each mode, the step sizes for each access size, the exactly-once register update, where a pointer chain ends and the byte extraction depend on data values. Only the bench's directed scenarios can show those, together with the absence of reads in the immediate and register modes.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [3:0] {
        AM_IMM   = 4'd0,
        AM_ABS   = 4'd1,
        AM_REG   = 4'd2,
        AM_RIND  = 4'd3,
        AM_MIND  = 4'd4,
        AM_IDX   = 4'd5,
        AM_BIDX  = 4'd6,
        AM_BIDXO = 4'd7,
        AM_AINC  = 4'd8,
        AM_ADEC  = 4'd9,
        AM_REL   = 4'd10
    } am_t;

    typedef enum logic [2:0] {
        S_IDLE, S_CALC, S_IND_READ, S_OP_READ, S_WRITEBACK, S_DONE
    } st_t;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] raddr_a,
    input  logic [RW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (we && waddr == RW'(g))
                regs_q[g] <= wdata;
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    mode,
    input  logic [DW-1:0] ra_val,
    input  logic [DW-1:0] rb_val,
    input  logic [DW-1:0] cst,
    input  logic [DW-1:0] pc,
    input  logic          byte_sz,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] wb_val,
    output logic          need_wb,
    output logic          direct,
    output logic [DW-1:0] direct_val,
    output logic          indirect
);
    logic [DW-1:0] step;

    always_comb begin
        step       = byte_sz ? DW'(1) : DW'(4);
        addr       = '0;
        wb_val     = ra_val;
        need_wb    = 1'b0;
        direct     = 1'b0;
        direct_val = '0;
        indirect   = 1'b0;
        case (am_t'(mode))
            AM_ABS:   addr = cst;
            AM_REG:   begin direct = 1'b1; direct_val = ra_val; end
            AM_RIND:  addr = ra_val;
            AM_MIND:  begin indirect = 1'b1; addr = cst; end
            AM_IDX:   addr = cst + ra_val;
            AM_BIDX:  addr = ra_val + rb_val;
            AM_BIDXO: addr = ra_val + rb_val + cst;
            AM_AINC:  begin addr = ra_val; wb_val = ra_val + step; need_wb = 1'b1; end
            AM_ADEC:  begin addr = ra_val - step; wb_val = ra_val - step; need_wb = 1'b1; end
            AM_REL:   addr = pc + cst;
            default:  begin direct = 1'b1; direct_val = cst; end
        endcase
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int NREG      = 8,
    parameter int DW        = 32,
    parameter int LEVEL_MAX = 8,
    localparam int RW       = $clog2(NREG),
    localparam int LW       = $clog2(LEVEL_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [RW-1:0] ra,
    input  logic [RW-1:0] rb,
    input  logic [DW-1:0] cst,
    input  logic          byte_sz,
    input  logic [DW-1:0] pc,
    input  logic          rf_we,
    input  logic [RW-1:0] rf_waddr,
    input  logic [DW-1:0] rf_wdata,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic [DW-1:0] operand,
    output logic [DW-1:0] ea,
    output logic          done,
    output logic          err
);
    localparam logic [LW-1:0] LVL_LAST = LW'(LEVEL_MAX - 1);

    st_t           state_q, state_d;
    logic [3:0]    mode_q;
    logic [RW-1:0] ra_q, rb_q;
    logic [DW-1:0] cst_q, pc_q, ea_q, ptr_q, opnd_q, wb_q;
    logic          byte_q, err_q, need_wb_q;
    logic [LW-1:0] lvl_q;

    logic [DW-1:0] ra_val, rb_val, c_addr, c_wb, c_dval;
    logic          c_need_wb, c_direct, c_indirect;
    logic          rf_we_int;
    logic [RW-1:0] rf_waddr_int;
    logic [DW-1:0] rf_wdata_int;
    logic          ptr_flag;
    logic [DW-1:0] ptr_next;

    assign ptr_flag = mem_rdata[DW-1];
    assign ptr_next = {1'b0, mem_rdata[DW-2:0]};

    ea_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we_int), .waddr(rf_waddr_int), .wdata(rf_wdata_int),
        .raddr_a(ra_q), .raddr_b(rb_q),
        .rdata_a(ra_val), .rdata_b(rb_val)
    );

    ea_addr_calc #(.DW(DW)) u_calc (
        .mode(mode_q), .ra_val(ra_val), .rb_val(rb_val), .cst(cst_q),
        .pc(pc_q), .byte_sz(byte_q),
        .addr(c_addr), .wb_val(c_wb), .need_wb(c_need_wb),
        .direct(c_direct), .direct_val(c_dval), .indirect(c_indirect)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_CALC;
            S_CALC:      state_d = c_direct ? S_DONE : (c_indirect ? S_IND_READ : S_OP_READ);
            S_IND_READ:  if (mem_ready) begin
                             if (!ptr_flag)              state_d = S_OP_READ;
                             else if (lvl_q == LVL_LAST) state_d = S_DONE;
                         end
            S_OP_READ:   if (mem_ready) state_d = need_wb_q ? S_WRITEBACK : S_DONE;
            S_WRITEBACK: state_d = S_DONE;
            S_DONE:      state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0; ra_q <= '0; rb_q <= '0; cst_q <= '0; pc_q <= '0;
            byte_q <= 1'b0; ea_q <= '0; ptr_q <= '0; opnd_q <= '0; wb_q <= '0;
            err_q <= 1'b0; need_wb_q <= 1'b0; lvl_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    mode_q <= mode; ra_q <= ra; rb_q <= rb; cst_q <= cst;
                    pc_q <= pc; byte_q <= byte_sz;
                    err_q <= 1'b0; lvl_q <= '0; opnd_q <= '0; ea_q <= '0;
                end
                S_CALC: begin
                    wb_q      <= c_wb;
                    need_wb_q <= c_need_wb;
                    if (c_direct)        opnd_q <= c_dval;
                    else if (c_indirect) ptr_q  <= c_addr;
                    else                 ea_q   <= c_addr;
                end
                S_IND_READ: if (mem_ready) begin
                    lvl_q <= lvl_q + 1'b1;
                    if (!ptr_flag)              ea_q  <= ptr_next;
                    else if (lvl_q == LVL_LAST) err_q <= 1'b1;
                    else                        ptr_q <= ptr_next;
                end
                S_OP_READ: if (mem_ready)
                    opnd_q <= byte_q ? {{(DW-8){1'b0}}, mem_rdata[7:0]} : mem_rdata;
                S_WRITEBACK, S_DONE: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req      = (state_q == S_IND_READ) || (state_q == S_OP_READ);
        mem_addr     = (state_q == S_IND_READ) ? ptr_q : ea_q;
        done         = (state_q == S_DONE);
        err          = err_q && (state_q == S_DONE);
        operand      = opnd_q;
        ea           = ea_q;
        rf_we_int    = (state_q == S_WRITEBACK) || rf_we;
        rf_waddr_int = (state_q == S_WRITEBACK) ? ra_q : rf_waddr;
        rf_wdata_int = (state_q == S_WRITEBACK) ? wb_q : rf_wdata;
    end
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
    parameter int DW        = 32,
    parameter int LEVEL_MAX = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          err,
    input logic          mem_req,
    input logic          mem_ready,
    input logic [DW-1:0] mem_addr
);
    logic [7:0] rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rd_cnt <= '0;
        else if (done)                 rd_cnt <= '0;
        else if (mem_req && mem_ready) rd_cnt <= rd_cnt + 1'b1;
    end

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_read_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rd_cnt) <= LEVEL_MAX + 1);

    p_no_req_at_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);
endmodule

bind ea_unit ea_unit_chk #(.DW(DW), .LEVEL_MAX(LEVEL_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .err(err),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr)
);

// File: tb/tb_ea_unit.sv
module tb_ea_unit;
    logic        clk = 0, rst_n = 0, start = 0, byte_sz = 0;
    logic [3:0]  mode = 0;
    logic [2:0]  ra = 0, rb = 0, rf_waddr = 0;
    logic [31:0] cst = 0, pc = 0, rf_wdata = 0;
    logic        rf_we = 0;
    logic        mem_req, mem_ready = 0, done, err;
    logic [31:0] mem_addr, mem_rdata = 0, operand, ea;

    ea_unit dut (.*);

    always #2 clk = ~clk;   // 250 MHz

    int n_chk = 0, n_bad = 0, lat = 0, wcnt = 0, rd_cnt = 0, cyc = 0;
    logic [31:0] mem [256];
    logic [31:0] r_op, r_ea;
    logic        r_err;
    int          r_rd;

    // memory model: ready after lat waiting cycles
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready <= 0; wcnt <= 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ready <= 1; mem_rdata <= mem[mem_addr[9:2]];
            end else wcnt <= wcnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_ready) rd_cnt <= rd_cnt + 1;
    end

    always @(posedge clk) if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_reg(logic [2:0] idx, logic [31:0] v);
        @(negedge clk); rf_we = 1; rf_waddr = idx; rf_wdata = v;
        @(negedge clk); rf_we = 0;
    endtask

    task automatic run(logic [3:0] m, logic [2:0] a, logic [2:0] b,
                       logic [31:0] c, logic bs);
        @(negedge clk);
        rd_cnt = 0;
        mode = m; ra = a; rb = b; cst = c; byte_sz = bs; start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 300 && !done; i++) @(negedge clk);
        r_op = operand; r_ea = ea; r_err = err; r_rd = rd_cnt;
        @(negedge clk);
    endtask

    task automatic reg_val(logic [2:0] a, output logic [31:0] v);
        run(4'd2, a, 3'd0, 32'd0, 1'b0);
        v = r_op;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 done", {31'd0, done}, 0);
        chk("R1 err", {31'd0, err}, 0);
        chk("R1 mem_req", {31'd0, mem_req}, 0);
        reg_val(3'd5, v); chk("R1 reg5 cleared", v, 0);
    endtask

    task automatic t_simple;
        logic [31:0] v;
        run(4'd0, 0, 0, 32'hFFFF_FFF0, 0);
        chk("R2 imm operand", r_op, 32'hFFFF_FFF0);
        chk("R2 imm ea", r_ea, 0);
        chk("R2 imm reads", r_rd, 0);
        run(4'd1, 0, 0, 32'h40, 0);
        chk("R3 abs ea", r_ea, 32'h40);
        chk("R3 abs operand", r_op, mem[8'h10]);
        chk("R3 abs reads", r_rd, 1);
        run(4'd2, 3'd2, 0, 0, 0);
        chk("R4 reg operand", r_op, 32'h20);
        chk("R4 reg reads", r_rd, 0);
        run(4'd3, 3'd1, 0, 0, 0);
        chk("R5 rind ea", r_ea, 32'h100);
        chk("R5 rind operand", r_op, mem[8'h40]);
        run(4'd5, 3'd1, 0, 32'hFFFF_FFFC, 0);
        chk("R6 idx ea", r_ea, 32'hFC);
        reg_val(3'd1, v); chk("R6 index reg kept", v, 32'h100);
        run(4'd6, 3'd1, 3'd2, 0, 0);
        chk("R7 base+index ea", r_ea, 32'h120);
        run(4'd7, 3'd1, 3'd2, 32'h10, 0);
        chk("R7 base+index+off ea", r_ea, 32'h130);
        pc = 32'h200;
        run(4'd10, 0, 0, 32'hFFFF_FFF0, 0);
        chk("R12 rel ea", r_ea, 32'h1F0);
    endtask

    task automatic t_indirect;
        run(4'd4, 0, 0, 32'h80, 0);
        chk("R8 one level ea", r_ea, 32'h300);
        chk("R8 one level operand", r_op, mem[8'hC0]);
        chk("R8 one level reads", r_rd, 2);
        run(4'd4, 0, 0, 32'h84, 0);
        chk("R8 two level ea", r_ea, 32'h304);
        chk("R8 two level reads", r_rd, 3);
        run(4'd4, 0, 0, 32'hA0, 0);
        chk("R9 seven flagged ea", r_ea, 32'h310);
        chk("R9 seven flagged err", {31'd0, r_err}, 0);
        chk("R9 seven flagged reads", r_rd, 9);
        run(4'd4, 0, 0, 32'h90, 0);
        chk("R9 runaway err", {31'd0, r_err}, 1);
        chk("R9 runaway reads", r_rd, 8);
        chk("R9 runaway ea", r_ea, 0);
        chk("R9 runaway operand", r_op, 0);
    endtask

    task automatic t_auto;
        logic [31:0] v;
        run(4'd8, 3'd3, 0, 0, 0);
        chk("R10 ainc word ea", r_ea, 32'h8);
        chk("R10 ainc word operand", r_op, mem[2]);
        reg_val(3'd3, v); chk("R10 ainc word reg", v, 32'hC);
        run(4'd8, 3'd3, 0, 0, 1);
        chk("R10 ainc byte ea", r_ea, 32'hC);
        chk("R10 ainc byte operand", r_op, {24'd0, mem[3][7:0]});
        reg_val(3'd3, v); chk("R10 ainc byte reg", v, 32'hD);
        run(4'd9, 3'd4, 0, 0, 0);
        chk("R11 adec word ea", r_ea, 32'h4C);
        reg_val(3'd4, v); chk("R11 adec word reg", v, 32'h4C);
        run(4'd9, 3'd4, 0, 0, 1);
        chk("R11 adec byte ea", r_ea, 32'h4B);
        reg_val(3'd4, v); chk("R11 adec byte reg", v, 32'h4B);
    endtask

    task automatic t_busy;
        int nd = 0;
        lat = 3;
        @(negedge clk);
        mode = 4'd1; cst = 32'h44; byte_sz = 0; start = 1;
        @(negedge clk); start = 0;
        @(negedge clk); mode = 4'd0; cst = 32'h1234; start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 40; i++) begin
            if (done) begin nd++; r_ea = ea; r_op = operand; end
            @(negedge clk);
        end
        chk("R13 single done", nd, 1);
        chk("R13 busy start ignored ea", r_ea, 32'h44);
        chk("R13 busy start ignored operand", r_op, mem[8'h11]);
        lat = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + i * 3;
        mem[8'h20] = 32'h0000_0300;
        mem[8'h21] = 32'h8000_0088;
        mem[8'h22] = 32'h0000_0304;
        mem[8'h24] = 32'h8000_0090;
        for (int k = 0; k < 7; k++) mem[8'h28 + k] = 32'h8000_0000 | (32'hA0 + 4 * (k + 1));
        mem[8'h2F] = 32'h0000_0310;
        mem[3]     = 32'h1234_56A7;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        set_reg(3'd1, 32'h100);
        set_reg(3'd2, 32'h20);
        set_reg(3'd3, 32'h8);
        set_reg(3'd4, 32'h50);
        t_simple;
        lat = 2;
        t_indirect;
        lat = 1;
        t_auto;
        t_busy;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule